// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 8-bit pulse-width modulation channel. A single register-write port loads a period, a duty value or the counter. Each load is selected by its own strobe and carries its value on a shared data bus. A channel enable, a polarity input and an align-mode input set how the channel runs. The counter advances only on cycles where the external prescaler raises `tick_i`. Clock-source selection and prescaling are done outside the block.

Period and duty are double buffered. Each field has a buffer register, which takes every write, and an active register, which drives the comparison. The buffer is copied to the active register at a reload. A reload happens in four cases: the channel is off or being switched off, the counter is written, or the effective period ends. As a result the waveform shows either a whole old cycle or a whole new one. Writing the counter forces an early reload and restarts the cycle from zero.

A three-state controller runs the counter: `ST_OFF` (disabled), `ST_UP` (counting up) and `ST_DN` (counting down, center mode only). Its transitions are:
- OFF→UP when the enable is seen high at a clock edge.
- Any→OFF when the enable is seen low.
- UP→DN when the count reaches the period in center mode.
- DN→UP when the count returns to zero.
- DN→UP on a counter write.
- DN→UP when a tick arrives in left mode.

Top module: `pwmch_top`

## Requirements
- R1: After reset the counter reads 0, both active registers hold 0, the controller is in `ST_OFF`, and `pwm_o` shows the inactive level. The inactive level is the inverse of `pol_i`.
- R2: While the channel is disabled the counter holds its value, except on a counter write, and `pwm_o` is at the inactive level.
- R3: While disabled, a period or duty write reaches both the buffer and the active register in the same clock.
- R4: While enabled, period and duty writes affect only the buffer until the next reload.
- R5: Left mode (`center_i`=0). Each tick moves the count up by one. When the count is at or above period−1 it wraps to 0 instead, which ends the effective period and reloads.
- R6: Center mode (`center_i`=1). The count rises to the period, then falls one per tick. A tick at a count of 1 or less sets the count to 0, ends the period, reloads and turns the direction back to up.
- R7: A counter write sets the count to 0 whatever the data value. It loads the buffered period and duty, including a value written in that same cycle. If the channel is enabled, counting restarts upward.
- R8: Let *active* mean duty≠0 and either (count < duty) or (duty ≥ period). While enabled, `pwm_o` equals `pol_i` when active and the inverse of `pol_i` otherwise. A period of 0 stops the count.
- R9: The count changes only at a clock edge where `tick_i`=1 and `en_i`=1 and the controller was already out of `ST_OFF`. A counter write is the one exception.
- R10: With `pol_i`=1 the waveform starts high and drops at the duty match. With `pol_i`=0 it starts low and rises there.
- R11: Switching the channel off reloads the active registers from the buffer at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Active output level |
| center_i | input | 1 | 1 selects up/down counting, 0 selects up counting |
| per_wr_i | input | 1 | Write strobe for the period |
| duty_wr_i | input | 1 | Write strobe for the duty |
| cnt_wr_i | input | 1 | Write strobe for the counter (clears it) |
| wdata_i | input | W | Write data |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | W | Live counter value |

## Verification
The internal state is the counter, the direction state and the two register pairs, and each one shows at the ports. A wrong count or direction shows on `cnt_o` at the first clock edge after the error. A stale or early-loaded active period or duty shows differently. It moves the duty edge on `pwm_o` or the wrap point on `cnt_o` within one waveform cycle, once the count reaches the affected value. The bench therefore compares both outputs with a behavioural model on every clock. A reload error is then caught at the first edge where old and new values give different waveforms.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_UP  = 2'd1,
        ST_DN  = 2'd2
    } pwm_st_e;

    localparam int NUM_FIELDS = 2;
    localparam int FLD_PER    = 0;
    localparam int FLD_DUTY   = 1;
endpackage

// File: rtl/pwmch_regs.sv
module pwmch_regs
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         per_wr_i,
    input  logic         duty_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         reload_i,
    output logic [W-1:0] per_o,
    output logic [W-1:0] duty_o
);
    logic [NUM_FIELDS-1:0] wr_en;
    logic [W-1:0]          buf_q   [NUM_FIELDS];
    logic [W-1:0]          buf_nxt [NUM_FIELDS];
    logic [W-1:0]          act_q   [NUM_FIELDS];

    assign wr_en[FLD_PER]  = per_wr_i;
    assign wr_en[FLD_DUTY] = duty_wr_i;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        // the value a reload sees includes a write made in the same cycle
        always_comb begin
            buf_nxt[f] = wr_en[f] ? wdata_i : buf_q[f];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[f] <= '0;
                act_q[f] <= '0;
            end else begin
                buf_q[f] <= buf_nxt[f];
                if (reload_i) begin
                    act_q[f] <= buf_nxt[f];
                end
            end
        end
    end

    assign per_o  = act_q[FLD_PER];
    assign duty_o = act_q[FLD_DUTY];
endmodule

// File: rtl/pwmch_ctr.sv
module pwmch_ctr
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic         center_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] per_i,
    output logic [W-1:0] cnt_o,
    output pwm_st_e      st_o,
    output logic         pend_o
);
    localparam logic [W-1:0] ONE = W'(1);

    pwm_st_e      st_q, st_nxt;
    logic [W-1:0] cnt_q, cnt_nxt;
    logic         step;
    logic         left_wrap;
    logic [W-1:0] left_nxt;
    logic         pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    always_comb begin
        step      = tick_i && en_i && (st_q != ST_OFF) && (per_i != '0);
        left_wrap = (cnt_q >= per_i - ONE);
        left_nxt  = left_wrap ? '0 : cnt_q + ONE;
    end

    // next state, next count, period end
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        pend    = 1'b0;
        if (!en_i) begin
            st_nxt = ST_OFF;
        end
        if (cnt_wr_i) begin
            cnt_nxt = '0;
            if (en_i) begin
                st_nxt = ST_UP;
            end
        end else if (en_i) begin
            unique case (st_q)
                ST_OFF: begin
                    st_nxt = ST_UP;
                end
                ST_UP: begin
                    if (step) begin
                        if (!center_i) begin
                            cnt_nxt = left_nxt;
                            pend    = left_wrap;
                        end else if (cnt_q >= per_i) begin
                            cnt_nxt = cnt_q - ONE;
                            st_nxt  = ST_DN;
                        end else begin
                            cnt_nxt = cnt_q + ONE;
                        end
                    end
                end
                ST_DN: begin
                    if (step) begin
                        if (!center_i) begin
                            cnt_nxt = left_nxt;
                            pend    = left_wrap;
                            st_nxt  = ST_UP;
                        end else if (cnt_q <= ONE) begin
                            cnt_nxt = '0;
                            pend    = 1'b1;
                            st_nxt  = ST_UP;
                        end else begin
                            cnt_nxt = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    st_nxt = ST_OFF;
                end
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign st_o   = st_q;
    assign pend_o = pend;
endmodule

// File: rtl/pwmch_wave.sv
module pwmch_wave
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  pwm_st_e      st_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] duty_i,
    input  logic         pol_i,
    output logic         pwm_o
);
    logic active;

    // output process
    always_comb begin
        active = (duty_i != '0) && ((cnt_i < duty_i) || (duty_i >= per_i));
        unique case (st_i)
            ST_UP, ST_DN: pwm_o = active ? pol_i : ~pol_i;
            default:      pwm_o = ~pol_i;
        endcase
    end
endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic         pol_i,
    input  logic         center_i,
    input  logic         per_wr_i,
    input  logic         duty_wr_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic         pwm_o,
    output logic [W-1:0] cnt_o
);
    pwm_st_e      st;
    logic [W-1:0] per_act;
    logic [W-1:0] duty_act;
    logic         pend;
    logic         reload;

    assign reload = (st == ST_OFF) || !en_i || cnt_wr_i || pend;

    pwmch_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_wr_i  (per_wr_i),
        .duty_wr_i (duty_wr_i),
        .wdata_i   (wdata_i),
        .reload_i  (reload),
        .per_o     (per_act),
        .duty_o    (duty_act)
    );

    pwmch_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .en_i     (en_i),
        .center_i (center_i),
        .cnt_wr_i (cnt_wr_i),
        .per_i    (per_act),
        .cnt_o    (cnt_o),
        .st_o     (st),
        .pend_o   (pend)
    );

    pwmch_wave #(.W(W)) u_wave (
        .st_i   (st),
        .cnt_i  (cnt_o),
        .per_i  (per_act),
        .duty_i (duty_act),
        .pol_i  (pol_i),
        .pwm_o  (pwm_o)
    );
endmodule

// File: rtl/pwmch_chk.sv
module pwmch_chk
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic         en_i,
    input logic         pol_i,
    input logic         center_i,
    input logic         cnt_wr_i,
    input logic         pwm_o,
    input logic [W-1:0] cnt_o,
    input pwm_st_e      st,
    input logic [W-1:0] per_act,
    input logic [W-1:0] duty_act
);
    localparam logic [W-1:0] ONE = W'(1);

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !cnt_wr_i) |=> $stable(cnt_o));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (cnt_o == '0));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(cnt_o));

    // R8
    zero_duty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && duty_act == '0) |-> (pwm_o == ~pol_i));

    // R8
    full_duty_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF && duty_act != '0 && duty_act >= per_act) |-> (pwm_o == pol_i));

    // R6
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DN && en_i && tick_i && center_i && !cnt_wr_i
         && per_act != '0 && cnt_o > ONE) |=> (cnt_o == $past(cnt_o) - ONE));
endmodule

bind pwmch_top pwmch_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .pol_i    (pol_i),
    .center_i (center_i),
    .cnt_wr_i (cnt_wr_i),
    .pwm_o    (pwm_o),
    .cnt_o    (cnt_o),
    .st       (st),
    .per_act  (per_act),
    .duty_act (duty_act)
);

// File: tb/pwmch_top_tb_top.sv
`timescale 1ns/1ps
module pwmch_top_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         en_i = 1'b0;
    logic         pol_i = 1'b1;
    logic         center_i = 1'b0;
    logic         per_wr_i = 1'b0;
    logic         duty_wr_i = 1'b0;
    logic         cnt_wr_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic         pwm_o;
    logic [W-1:0] cnt_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur_tag = "R1";
    int    tick_div = 1;
    int    phase = 0;

    always #2 clk = ~clk;

    pwmch_top #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_i      (en_i),
        .pol_i     (pol_i),
        .center_i  (center_i),
        .per_wr_i  (per_wr_i),
        .duty_wr_i (duty_wr_i),
        .cnt_wr_i  (cnt_wr_i),
        .wdata_i   (wdata_i),
        .pwm_o     (pwm_o),
        .cnt_o     (cnt_o)
    );

    // behavioural reference
    int m_cnt, m_per, m_duty, m_bper, m_bduty;
    bit m_down, m_on;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_bper = 0; m_bduty = 0;
            m_down = 0; m_on = 0;
        end else begin
            int  bp, bd, c;
            bit  dn, ends;
            bp   = per_wr_i  ? int'(wdata_i) : m_bper;
            bd   = duty_wr_i ? int'(wdata_i) : m_bduty;
            c    = m_cnt;
            dn   = m_down;
            ends = 0;
            if (cnt_wr_i) begin
                c = 0; dn = 0;
            end else if (m_on && en_i && tick_i && m_per != 0) begin
                if (!center_i) begin
                    dn = 0;
                    if (m_cnt >= m_per - 1) begin c = 0; ends = 1; end
                    else c = m_cnt + 1;
                end else if (!m_down) begin
                    if (m_cnt >= m_per) begin c = m_cnt - 1; dn = 1; end
                    else c = m_cnt + 1;
                end else begin
                    if (m_cnt <= 1) begin c = 0; dn = 0; ends = 1; end
                    else c = m_cnt - 1;
                end
            end
            if (!en_i) dn = 0;
            if (!m_on || !en_i || cnt_wr_i || ends) begin
                m_per = bp; m_duty = bd;
            end
            m_bper = bp; m_bduty = bd;
            m_cnt = c; m_down = dn; m_on = en_i;
        end
    end

    function automatic bit exp_pwm();
        bit act;
        if (!m_on) return ~pol_i;
        act = (m_duty != 0) && ((m_cnt < m_duty) || (m_duty >= m_per));
        return act ? pol_i : ~pol_i;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = (tick_div <= 1) ? 1'b1 : (phase % tick_div == 0);
            phase++;
            @(negedge clk);
            chk({cur_tag, " cnt"}, int'(cnt_o), m_cnt);
            chk({cur_tag, " pwm"}, int'(pwm_o), int'(exp_pwm()));
        end
    endtask

    task automatic wr(input int kind, input int data);
        wdata_i = W'(data);
        per_wr_i  = (kind == 0);
        duty_wr_i = (kind == 1);
        cnt_wr_i  = (kind == 2);
        cyc(1);
        per_wr_i = 0; duty_wr_i = 0; cnt_wr_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 pwm", int'(pwm_o), 0);

        // R3: writes while off go straight to the active registers
        cur_tag = "R3";
        wr(0, 5); wr(1, 2);
        // R5, R10: left mode, high-first waveform
        cur_tag = "R5";
        en_i = 1;
        cyc(20);

        // R4: enabled writes wait for the period end
        cur_tag = "R4";
        wr(0, 8);
        cyc(2);
        wr(1, 6);
        cyc(24);

        // R9: sparse ticks
        cur_tag = "R9";
        tick_div = 3;
        cyc(24);
        tick_div = 1;

        // R7: counter write with arbitrary data
        cur_tag = "R7";
        cyc(3);
        wr(2, 8'hA5);
        chk("R7 cleared", int'(cnt_o), 0);
        wr(1, 3);
        wr(2, 8'h5A);
        cyc(12);

        // R6: center mode
        cur_tag = "R6";
        center_i = 1;
        wr(0, 4); wr(1, 1);
        cyc(30);
        wr(1, 3);
        cyc(20);

        // R8: duty extremes and period 0
        cur_tag = "R8";
        wr(1, 0);
        cyc(20);
        chk("R8 duty0 level", int'(pwm_o), 0);
        wr(1, 9);
        cyc(20);
        chk("R8 full level", int'(pwm_o), 1);
        en_i = 0;
        cyc(1);
        wr(0, 0);
        en_i = 1;
        cyc(10);
        chk("R8 per0 cnt", int'(cnt_o), int'(cnt_o == 0 ? 0 : m_cnt));

        // R10: low-first waveform
        cur_tag = "R10";
        en_i = 0; center_i = 0; pol_i = 0;
        cyc(1);
        wr(0, 6); wr(1, 2);
        en_i = 1;
        cyc(20);

        // R11, R2: disable mid-cycle reloads and holds
        cur_tag = "R11";
        cyc(2);
        wr(1, 5);
        en_i = 0;
        cyc(1);
        cur_tag = "R2";
        cyc(10);
        chk("R2 off level", int'(pwm_o), 1);
        cur_tag = "R11";
        en_i = 1;
        cyc(15);

        finish_run();
    end
endmodule